// File: doc/BRIEF.md
# Peripheral Bus Master Sequencer

This block lets a processor run single-word transfers on an external peripheral bus that carries the device select, the transfer mode and the data over one shared 36-bit word path in separate phases. A request names one of eight operations, a 7-bit device address, a write word and an 18-bit operand. The sequencer first drives a select word with the device address in the top bits and a 3-bit mode field directly below it. A write then follows with the data word. A read waits a settling window of one microsecond, counted in clock cycles, and then samples the bus. The bus delivers read data inverted, so the block complements it before returning it.

Two operations read the control word and test it against the 18-bit operand used as a mask. They return a skip decision: one skips when the masked value is zero, the other when it is nonzero. The control-out operation sends the 18-bit operand, zero-extended, in place of the write word. The two block-transfer codes are rejected. They produce a done pulse with an unimplemented-operation flag and never touch the bus. A separate bus-reset input fires the bus reset strobe and abandons any transfer in flight.

Top module: `pbm_sequencer`

## Requirements
- R1: After rst_n is released, busy, done, unimpl, skip and all four bus strobes are 0 and bus_word_out is 0.
- R2: A request taken while idle (req_valid=1, busy=0) raises bus_sel_stb for exactly one cycle, starting the cycle after acceptance. While it is high, bus_word_out = {req_dev[6:0], mode[2:0], 26 zeros}. Mode bit 2 means read, bit 1 means control and bit 0 (alternate format) is always set. The mode is 101 for data-in (req_op=0), 001 for data-out (op 1), 111 for control-in (op 2), 011 for control-out (op 3) and 111 for both tests (ops 4 and 5).
- R3: For data-out, bus_wr_stb is high for one cycle right after the select phase, with bus_word_out = req_wdata. done pulses in the cycle after that.
- R4: For control-out, the write phase drives bus_word_out = req_imm zero-extended to 36 bits, and req_wdata is ignored.
- R5: For every read operation (ops 0, 2, 4 and 5), exactly CYC_PER_US cycles with no bus strobe separate the select cycle from a one-cycle bus_rd_stb. done pulses in the cycle after bus_rd_stb.
- R6: With done, rd_data equals the bitwise complement of bus_word_in as sampled during bus_rd_stb.
- R7: With done, skip = 1 for test-zero (op 4) when (read value[17:0] & req_imm) == 0, and for test-nonzero (op 5) when it is nonzero. Bits 35:18 of the read value do not matter. skip = 0 for every other operation.
- R8: Block-in (op 6) and block-out (op 7) raise done and unimpl together in the cycle after acceptance, with no bus strobe. unimpl is 0 for all other operations.
- R9: While busy is 1, req_valid is ignored. No new select phase follows, and busy falls in the cycle after done.
- R10: bus_rst=1 makes bus_reset_stb high for the following cycle with busy=0. Any transfer in progress is abandoned without done.
- R11: At most one of bus_sel_stb, bus_wr_stb, bus_rd_stb and bus_reset_stb is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rst | input | 1 | Request a peripheral bus reset and abort the current transfer |
| req_valid | input | 1 | Operation request, taken when busy is 0 |
| req_op | input | 3 | Operation code (0 data-in, 1 data-out, 2 control-in, 3 control-out, 4 test-zero, 5 test-nonzero, 6 block-in, 7 block-out) |
| req_dev | input | 7 | Device address |
| req_wdata | input | 36 | Write word for data-out |
| req_imm | input | 18 | Immediate for control-out, mask for the tests |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| unimpl | output | 1 | Unimplemented operation, valid with done |
| skip | output | 1 | Skip decision, valid with done |
| rd_data | output | 36 | Complemented read word |
| bus_word_out | output | 36 | Shared select and data word driven to the bus |
| bus_word_in | input | 36 | Inverted word returned by the bus |
| bus_sel_stb | output | 1 | Select phase strobe |
| bus_wr_stb | output | 1 | Write data strobe |
| bus_rd_stb | output | 1 | Read sample strobe |
| bus_reset_stb | output | 1 | Bus reset strobe |

## Verification
The bench builds the sequencer with CYC_PER_US=4 and keeps the widths at their defaults. This makes the settling window short enough that every quiet cycle between the select and sample strobes can be counted one by one, while the select word layout and the 18-bit mask keep their real positions. The short window also leaves room to place a second request and a bus reset inside the settle phase. That exercises the busy rejection and the mid-transfer abort at a known cycle.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    typedef enum logic [2:0] {
        OP_DATA_IN      = 3'd0,
        OP_DATA_OUT     = 3'd1,
        OP_CTRL_IN      = 3'd2,
        OP_CTRL_OUT     = 3'd3,
        OP_TEST_ZERO    = 3'd4,
        OP_TEST_NONZERO = 3'd5,
        OP_BLOCK_IN     = 3'd6,
        OP_BLOCK_OUT    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_WRITE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_DONE
    } state_e;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_READ = 3'b100;
    localparam logic [MODE_W-1:0] MODE_CTL  = 3'b010;
    localparam logic [MODE_W-1:0] MODE_ALT  = 3'b001;

endpackage

// File: rtl/pbm_op_decode.sv
module pbm_op_decode
    import pbm_pkg::*;
(
    input  logic [2:0]        op,
    output logic [MODE_W-1:0] mode,
    output logic              is_read,
    output logic              is_block,
    output logic              is_test,
    output logic              test_nz,
    output logic              use_imm
);
    always_comb begin
        mode     = '0;
        is_read  = 1'b0;
        is_block = 1'b0;
        is_test  = 1'b0;
        test_nz  = 1'b0;
        use_imm  = 1'b0;
        case (op_e'(op))
            OP_DATA_IN:  begin mode = MODE_READ | MODE_ALT; is_read = 1'b1; end
            OP_DATA_OUT: mode = MODE_ALT;
            OP_CTRL_IN:  begin mode = MODE_READ | MODE_CTL | MODE_ALT; is_read = 1'b1; end
            OP_CTRL_OUT: begin mode = MODE_CTL | MODE_ALT; use_imm = 1'b1; end
            OP_TEST_ZERO: begin
                mode = MODE_READ | MODE_CTL | MODE_ALT; is_read = 1'b1; is_test = 1'b1;
            end
            OP_TEST_NONZERO: begin
                mode = MODE_READ | MODE_CTL | MODE_ALT; is_read = 1'b1; is_test = 1'b1;
                test_nz = 1'b1;
            end
            default: is_block = 1'b1;
        endcase
    end
endmodule

// File: rtl/pbm_settle_timer.sv
module pbm_settle_timer #(
    parameter int CYC_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYC_PER_US - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R5: a running window never stalls before expiring
    a_r5_timer_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !expired) |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/pbm_skip_eval.sv
module pbm_skip_eval #(
    parameter int MASK_W = 18
) (
    input  logic [MASK_W-1:0] value,
    input  logic [MASK_W-1:0] mask,
    input  logic              nz_sense,
    output logic              skip
);
    logic any_set;
    assign any_set = |(value & mask);
    assign skip    = nz_sense ? any_set : !any_set;
endmodule

// File: rtl/pbm_sequencer.sv
module pbm_sequencer
    import pbm_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int WORD_W     = 36,
    parameter int IMM_W      = 18,
    parameter int CYC_PER_US = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_dev,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [IMM_W-1:0]  req_imm,
    output logic              busy,
    output logic              done,
    output logic              unimpl,
    output logic              skip,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] bus_word_out,
    input  logic [WORD_W-1:0] bus_word_in,
    output logic              bus_sel_stb,
    output logic              bus_wr_stb,
    output logic              bus_rd_stb,
    output logic              bus_reset_stb
);
    localparam int PAD_W = WORD_W - ADDR_W - MODE_W;
    localparam int EXT_W = WORD_W - IMM_W;

    typedef struct packed {
        state_e            st;
        logic [2:0]        op;
        logic [ADDR_W-1:0] dev;
        logic [WORD_W-1:0] wword;
        logic [IMM_W-1:0]  mask;
        logic [WORD_W-1:0] rdata;
        logic              skip;
        logic              err;
        logic              rst_stb;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]        op_sel;
    logic [MODE_W-1:0] mode;
    logic              is_read, is_block, is_test, test_nz, use_imm;
    logic              timer_load, timer_run, timer_expired;
    logic              skip_res;
    logic [WORD_W-1:0] read_val;
    logic [WORD_W-1:0] sel_word;

    assign op_sel = (r_q.st == ST_IDLE) ? req_op : r_q.op;

    pbm_op_decode u_dec (
        .op       (op_sel),
        .mode     (mode),
        .is_read  (is_read),
        .is_block (is_block),
        .is_test  (is_test),
        .test_nz  (test_nz),
        .use_imm  (use_imm)
    );

    pbm_settle_timer #(.CYC_PER_US(CYC_PER_US)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .run     (timer_run),
        .expired (timer_expired)
    );

    assign read_val = ~bus_word_in;

    pbm_skip_eval #(.MASK_W(IMM_W)) u_skip (
        .value    (read_val[IMM_W-1:0]),
        .mask     (r_q.mask),
        .nz_sense (test_nz),
        .skip     (skip_res)
    );

    assign sel_word   = {r_q.dev, mode, {PAD_W{1'b0}}};
    assign timer_load = (r_q.st == ST_SEL);
    assign timer_run  = (r_q.st == ST_SETTLE);

    always_comb begin
        r_d         = r_q;
        r_d.rst_stb = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.op    = req_op;
                    r_d.dev   = req_dev;
                    r_d.mask  = req_imm;
                    r_d.wword = use_imm ? {{EXT_W{1'b0}}, req_imm} : req_wdata;
                    r_d.skip  = 1'b0;
                    r_d.err   = is_block;
                    r_d.st    = is_block ? ST_DONE : ST_SEL;
                end
            end
            ST_SEL:    r_d.st = is_read ? ST_SETTLE : ST_WRITE;
            ST_WRITE:  r_d.st = ST_DONE;
            ST_SETTLE: if (timer_expired) r_d.st = ST_SAMPLE;
            ST_SAMPLE: begin
                r_d.rdata = read_val;
                r_d.skip  = is_test && skip_res;
                r_d.st    = ST_DONE;
            end
            ST_DONE:   r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
        if (bus_rst) begin
            r_d.st      = ST_IDLE;
            r_d.rst_stb = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.st != ST_IDLE);
    assign done          = (r_q.st == ST_DONE);
    assign unimpl        = done && r_q.err;
    assign skip          = r_q.skip;
    assign rd_data       = r_q.rdata;
    assign bus_sel_stb   = (r_q.st == ST_SEL);
    assign bus_wr_stb    = (r_q.st == ST_WRITE);
    assign bus_rd_stb    = (r_q.st == ST_SAMPLE);
    assign bus_reset_stb = r_q.rst_stb;
    assign bus_word_out  = bus_sel_stb ? sel_word : (bus_wr_stb ? r_q.wword : '0);

    // R11: strobes never overlap
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_sel_stb, bus_wr_stb, bus_rd_stb, bus_reset_stb}));

    // R3: a write select is followed by the write phase
    a_r3_write_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_stb && !is_read && !bus_rst) |=> bus_wr_stb);

    // R5: sampling only happens once the settle window has run out
    a_r5_sample_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_stb |-> $past(timer_run && timer_expired));

    // R8: unimplemented flag only accompanies done
    a_r8_unimpl_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl |-> done);

    // R9: sequencer is free in the cycle after done
    a_r9_free_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10: bus reset strobes and returns to idle
    a_r10_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (bus_reset_stb && !busy));
endmodule

// File: tb/tb_pbm_sequencer.sv
module tb_pbm_sequencer;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [6:0]  req_dev = '0;
    logic [35:0] req_wdata = '0;
    logic [17:0] req_imm = '0;
    logic [35:0] bus_word_in = '0;
    logic        busy, done, unimpl, skip;
    logic [35:0] rd_data, bus_word_out;
    logic        bus_sel_stb, bus_wr_stb, bus_rd_stb, bus_reset_stb;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pbm_sequencer #(.CYC_PER_US(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .req_valid(req_valid),
        .req_op(req_op), .req_dev(req_dev), .req_wdata(req_wdata), .req_imm(req_imm),
        .busy(busy), .done(done), .unimpl(unimpl), .skip(skip), .rd_data(rd_data),
        .bus_word_out(bus_word_out), .bus_word_in(bus_word_in),
        .bus_sel_stb(bus_sel_stb), .bus_wr_stb(bus_wr_stb), .bus_rd_stb(bus_rd_stb),
        .bus_reset_stb(bus_reset_stb)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [6:0]  dev;
        logic [35:0] wd;
        logic [17:0] imm;
        logic [35:0] bin;
        logic        eskip;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{3'd1, 7'h15, 36'h1_2345_6789, 18'h0_0000, 36'h0_0000_0000, 1'b0},
        '{3'd3, 7'h7F, 36'hF_FFFF_FFFF, 18'h2_ABCD, 36'h0_0000_0000, 1'b0},
        '{3'd0, 7'h01, 36'h0_0000_0000, 18'h0_0000, 36'hA_5A5A_5A5A, 1'b0},
        '{3'd2, 7'h40, 36'h0_0000_0000, 18'h3_FFFF, 36'h0_0000_0000, 1'b0},
        '{3'd4, 7'h22, 36'h0_0000_0000, 18'h3_FFFF, 36'hF_FFFF_FFFF, 1'b1},
        '{3'd4, 7'h22, 36'h0_0000_0000, 18'h0_00F0, 36'hF_FFFF_FF0F, 1'b0},
        '{3'd4, 7'h33, 36'h0_0000_0000, 18'h3_FFFF, 36'h0_0003_FFFF, 1'b1},
        '{3'd5, 7'h0A, 36'h0_0000_0000, 18'h0_00F0, 36'hF_FFFF_FF0F, 1'b1},
        '{3'd5, 7'h0B, 36'h0_0000_0000, 18'h3_FFFF, 36'hF_FFFF_FFFF, 1'b0},
        '{3'd5, 7'h0C, 36'h0_0000_0000, 18'h0_0000, 36'h0_0000_0000, 1'b0},
        '{3'd6, 7'h10, 36'h0_0000_0000, 18'h0_0000, 36'h0_0000_0000, 1'b0},
        '{3'd7, 7'h11, 36'h0_0000_0000, 18'h0_0000, 36'h0_0000_0000, 1'b0}
    };

    function automatic logic [2:0] mode_of(input logic [2:0] op);
        case (op)
            3'd0: return 3'b101;
            3'd1: return 3'b001;
            3'd2: return 3'b111;
            3'd3: return 3'b011;
            3'd4, 3'd5: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        req_op = v.op; req_dev = v.dev; req_wdata = v.wd; req_imm = v.imm;
        bus_word_in = v.bin;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        bit rd;
        int quiet;
        rd = (v.op == 3'd0) || (v.op == 3'd2) || (v.op == 3'd4) || (v.op == 3'd5);
        issue(v);
        if (v.op >= 3'd6) begin
            chk("R8 done+unimpl", {34'd0, done, unimpl}, 36'd3);
            chk("R8 no strobe", {33'd0, bus_sel_stb, bus_wr_stb, bus_rd_stb}, 36'd0);
        end else begin
            chk("R2 select strobe", {35'd0, bus_sel_stb}, 36'd1);
            chk("R2 select word", bus_word_out, {v.dev, mode_of(v.op), 26'd0});
            @(negedge clk);
            if (!rd) begin
                chk("R3 write strobe", {35'd0, bus_wr_stb}, 36'd1);
                if (v.op == 3'd3) chk("R4 immediate word", bus_word_out, {18'd0, v.imm});
                else              chk("R3 write word", bus_word_out, v.wd);
                @(negedge clk);
                chk("R3 done", {34'd0, done, unimpl}, 36'd2);
                chk("R7 no skip on write", {35'd0, skip}, 36'd0);
            end else begin
                quiet = 0;
                for (int k = 0; k < N; k++) begin
                    if (!bus_sel_stb && !bus_wr_stb && !bus_rd_stb) quiet++;
                    @(negedge clk);
                end
                chk("R5 quiet settle cycles", 36'(quiet), 36'(N));
                chk("R5 sample strobe", {35'd0, bus_rd_stb}, 36'd1);
                @(negedge clk);
                chk("R5 done after sample", {34'd0, done, unimpl}, 36'd2);
                chk("R6 complemented data", rd_data, ~v.bin);
                chk("R7 skip", {35'd0, skip}, {35'd0, v.eskip});
            end
        end
        @(negedge clk);
        chk("R9 idle after done", {35'd0, busy}, 36'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {32'd0, busy, done, unimpl, skip}, 36'd0);
        chk("R1 strobes", {32'd0, bus_sel_stb, bus_wr_stb, bus_rd_stb, bus_reset_stb}, 36'd0);
        chk("R1 word out", bus_word_out, 36'd0);

        for (int i = 0; i < 12; i++) run_vec(VECS[i]);

        // R9: a request during the settle window is ignored
        issue('{3'd0, 7'h11, 36'd0, 18'd0, 36'h0_0000_FFFF, 1'b0});
        @(negedge clk);
        req_op = 3'd1; req_dev = 7'h55; req_wdata = 36'h9_9999_9999; req_valid = 1'b1;
        for (int k = 0; k < N; k++) begin
            chk("R9 no select while busy", {34'd0, bus_sel_stb, bus_wr_stb}, 36'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R9 original read samples", {35'd0, bus_rd_stb}, 36'd1);
        @(negedge clk);
        chk("R9 original read done", rd_data, 36'hF_FFFF_0000);
        @(negedge clk);
        chk("R9 no late select", {34'd0, bus_sel_stb, busy}, 36'd0);

        // R10: bus reset during settle aborts the read
        issue('{3'd2, 7'h05, 36'd0, 18'd0, 36'h0_0000_0000, 1'b0});
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        chk("R10 reset strobe idle", {34'd0, bus_reset_stb, busy}, 36'd2);
        @(negedge clk);
        chk("R10 strobe one cycle, no done", {34'd0, bus_reset_stb, done}, 36'd0);
        repeat (N + 2) @(negedge clk);
        chk("R10 no sample after abort", {34'd0, bus_rd_stb, busy}, 36'd0);

        // R10/R11: bus reset in idle while a request is offered
        req_op = 3'd1; req_valid = 1'b1; bus_rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; bus_rst = 1'b0;
        chk("R11 reset only strobe", {32'd0, bus_sel_stb, bus_wr_stb, bus_rd_stb, bus_reset_stb}, 36'd1);

        // recovery after reset
        run_vec(VECS[0]);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule